// File: doc/BRIEF.md
# Selectable Pixel Point-Operation Enhancer

This block is a streaming per-pixel enhancer for RGB image data. Each clock it can accept two adjacent pixels. Each pixel carries three 8-bit channels, so six channel values arrive together. The same operation is applied to every channel, chosen from four options:

- brightness shift up or down by a constant, saturating at the ends of the 8-bit range;
- negative;
- binary threshold against a programmable level;
- pass-through.

The operation code, brightness constant, brightness direction and threshold level are static configuration inputs. The input stream is qualified by a valid strobe. Results leave one register stage later with a matching valid strobe, in the order they arrived.

The block sits between a pixel source and a pixel sink. It needs no handshake of its own, because every accepted pixel pair produces exactly one result pair after a fixed latency.

Top module: `pixel_point_enhancer`

## Requirements
- R1: Each cycle the input bus carries two pixels. Pixel 0 occupies bits [23:0] and pixel 1 occupies bits [47:24]. Within a pixel, red is in the top byte, green in the middle byte and blue in the bottom byte. Each of the six channels is processed on its own, into the same position on the output bus.
- R2: With op_sel = 2'b00 and bright_up = 1, each output channel is the input channel plus bright_amt, clamped to 255 when the sum exceeds 255.
- R3: With op_sel = 2'b00 and bright_up = 0, each output channel is the input channel minus bright_amt, clamped to 0 when the difference is negative.
- R4: bright_amt takes any value from 0 to 255. The typical setting is 100. A constant of 0 leaves channels unchanged, and a constant of 255 drives every channel to a range end.
- R5: With op_sel = 2'b01, each output channel is 255 minus the input channel.
- R6: With op_sel = 2'b10, a channel strictly greater than thr_level gives 255. Any other channel, including one equal to the level, gives 0. Levels such as 90 and 80 are set through thr_level.
- R7: With op_sel = 2'b11, each output channel equals the input channel.
- R8: out_valid equals in_valid delayed by exactly one clock. The result for a pixel pair accepted at an edge appears at that same edge, so pixel order is preserved.
- R9: The output data changes only at an edge where in_valid is 1. While in_valid is 0, changes to the data or configuration inputs leave out_pix unchanged.
- R10: While rst_n is low, out_valid is 0 and out_pix is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel pair is valid this cycle |
| in_pix | input | 48 | Two RGB pixels, packed as in R1 |
| op_sel | input | 2 | Operation code: 00 brightness, 01 negative, 10 threshold, 11 pass-through |
| bright_amt | input | 8 | Brightness constant |
| bright_up | input | 1 | 1 adds the constant, 0 subtracts it |
| thr_level | input | 8 | Threshold level |
| out_valid | output | 1 | Output pixel pair is valid |
| out_pix | output | 48 | Processed pixel pair, same packing as in_pix |

## Verification
The hardest situation to reach is a pair in which some channels saturate while their neighbours do not. A saturation or lane-slicing fault then shows up in only one byte. The vector table therefore mixes bytes that land exactly on 255 or 0 with bytes that overshoot by one and bytes far from either end, in both pixels of the same beat. Threshold vectors place channels at level-1, level and level+1. The hold behaviour is reached by dropping the valid strobe after a stream and then changing the operation code and the data while the output is watched.

// File: rtl/pxe_pkg.sv
package pxe_pkg;

   typedef enum logic [1:0] {
      OP_BRIGHT = 2'b00,
      OP_NEGATE = 2'b01,
      OP_THRESH = 2'b10,
      OP_PASS   = 2'b11
   } pxe_op_e;

endpackage

// File: rtl/pxe_sat_adj.sv
// Saturating add or subtract of an unsigned constant on one channel.
module pxe_sat_adj #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] amt,
   input  logic         up,
   output logic [W-1:0] y
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W:0] sum_w;
   logic [W:0] dif_w;

   always_comb begin
      sum_w = {1'b0, x} + {1'b0, amt};
      dif_w = {1'b0, x} - {1'b0, amt};
      if (up)
         y = sum_w[W] ? TOP : sum_w[W-1:0];
      else
         y = dif_w[W] ? '0 : dif_w[W-1:0];
   end
endmodule

// File: rtl/pxe_chan_op.sv
// One channel: all four point operations and the selecting mux.
module pxe_chan_op
   import pxe_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  pxe_op_e      op,
   input  logic [W-1:0] amt,
   input  logic         up,
   input  logic [W-1:0] level,
   output logic [W-1:0] y
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] adj_y;

   pxe_sat_adj #(.W(W)) adj_i (
      .x  (x),
      .amt(amt),
      .up (up),
      .y  (adj_y)
   );

   always_comb begin
      unique case (op)
         OP_BRIGHT: y = adj_y;
         OP_NEGATE: y = TOP - x;
         OP_THRESH: y = (x > level) ? TOP : '0;
         default:   y = x;
      endcase
   end
endmodule

// File: rtl/pixel_point_enhancer.sv
module pixel_point_enhancer
   import pxe_pkg::*;
#(
   parameter int CHAN_W = 8,
   parameter int CHANS  = 3,
   parameter int LANES  = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              in_valid,
   input  logic [LANES*CHANS*CHAN_W-1:0]     in_pix,
   input  logic [1:0]                        op_sel,
   input  logic [CHAN_W-1:0]                 bright_amt,
   input  logic                              bright_up,
   input  logic [CHAN_W-1:0]                 thr_level,
   output logic                              out_valid,
   output logic [LANES*CHANS*CHAN_W-1:0]     out_pix
);
   localparam int NCH   = LANES * CHANS;
   localparam int BUS_W = NCH * CHAN_W;

   if (CHAN_W < 2 || CHAN_W > 16) begin : g_bad_w
      $error("pixel_point_enhancer: CHAN_W out of range");
   end
   if (CHANS < 1 || LANES < 1) begin : g_bad_n
      $error("pixel_point_enhancer: CHANS and LANES must be positive");
   end

   pxe_op_e          op_e;
   logic [BUS_W-1:0] res_c;

   assign op_e = pxe_op_e'(op_sel);

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      pxe_chan_op #(.W(CHAN_W)) op_i (
         .x    (in_pix[k*CHAN_W +: CHAN_W]),
         .op   (op_e),
         .amt  (bright_amt),
         .up   (bright_up),
         .level(thr_level),
         .y    (res_c[k*CHAN_W +: CHAN_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_pix <= res_c;
      end
   end

   // Checks. armed rises one edge after reset, so every $past refers to a post-reset cycle.
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_valid_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> out_valid == $past(in_valid));

   assert_reg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(in_valid)) |-> $stable(out_pix));

   for (genvar k = 0; k < NCH; k++) begin : g_chk
      assert_bright_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $past(in_valid) && $past(op_sel) == 2'b00 && $past(bright_up))
         |-> out_pix[k*CHAN_W +: CHAN_W] >= $past(in_pix[k*CHAN_W +: CHAN_W]));

      assert_bright_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $past(in_valid) && $past(op_sel) == 2'b00 && !$past(bright_up))
         |-> out_pix[k*CHAN_W +: CHAN_W] <= $past(in_pix[k*CHAN_W +: CHAN_W]));

      assert_negate_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $past(in_valid) && $past(op_sel) == 2'b01)
         |-> out_pix[k*CHAN_W +: CHAN_W] == ~$past(in_pix[k*CHAN_W +: CHAN_W]));

      assert_thresh_two_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $past(in_valid) && $past(op_sel) == 2'b10)
         |-> (out_pix[k*CHAN_W +: CHAN_W] == '0 ||
              out_pix[k*CHAN_W +: CHAN_W] == {CHAN_W{1'b1}}));

      assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $past(in_valid) && $past(op_sel) == 2'b11)
         |-> out_pix[k*CHAN_W +: CHAN_W] == $past(in_pix[k*CHAN_W +: CHAN_W]));
   end
endmodule

// File: tb/pixel_point_enhancer_tb.sv
module pixel_point_enhancer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [47:0] in_pix;
   logic [1:0]  op_sel;
   logic [7:0]  bright_amt;
   logic        bright_up;
   logic [7:0]  thr_level;
   logic        out_valid;
   logic [47:0] out_pix;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   pixel_point_enhancer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_pix    (in_pix),
      .op_sel    (op_sel),
      .bright_amt(bright_amt),
      .bright_up (bright_up),
      .thr_level (thr_level),
      .out_valid (out_valid),
      .out_pix   (out_pix)
   );

   // {op, up, amt, level, input pair, expected pair}
   localparam int NV = 10;
   localparam logic [114:0] VEC [NV] = '{
      {2'b00, 1'b1, 8'd100, 8'd0,   48'hC8009B_9C10FF, 48'hFF64FF_FF74FF}, // R1 R2 R4 clamp at 255
      {2'b00, 1'b0, 8'd100, 8'd0,   48'h6463C8_00FF65, 48'h000064_009B01}, // R3 R4 clamp at 0
      {2'b00, 1'b1, 8'd0,   8'd0,   48'h123456_ABCDEF, 48'h123456_ABCDEF}, // R4 zero constant
      {2'b00, 1'b0, 8'd255, 8'd0,   48'hFFFE00_8001FF, 48'h000000_000000}, // R4 full constant down
      {2'b01, 1'b1, 8'd100, 8'd0,   48'h00FF80_7F1234, 48'hFF007F_80EDCB}, // R5 negative
      {2'b10, 1'b0, 8'd100, 8'd90,  48'h5A5B59_00FFA0, 48'h00FF00_00FFFF}, // R6 level 90
      {2'b10, 1'b1, 8'd7,   8'd80,  48'h50515A_4F00FF, 48'h00FFFF_0000FF}, // R6 level 80
      {2'b10, 1'b0, 8'd0,   8'd255, 48'hFFFFFE_0080FF, 48'h000000_000000}, // R6 level at max
      {2'b11, 1'b1, 8'd200, 8'd3,   48'hA5C3E1_0F1E2D, 48'hA5C3E1_0F1E2D}, // R7 pass-through
      {2'b00, 1'b1, 8'd155, 8'd0,   48'h646500_FF019C, 48'hFFFF9B_FF9CFF}  // R2 exact and over by one
   };

   task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   initial begin
      repeat (4000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R8 watchdog act=running exp=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [47:0] last_exp;
      rst_n = 1'b0; in_valid = 1'b0; in_pix = '0; op_sel = 2'b00;
      bright_amt = 8'd100; bright_up = 1'b1; thr_level = 8'd90;
      repeat (3) @(negedge clk);
      chk("R10 reset valid", {47'd0, out_valid}, 48'd0);
      chk("R10 reset data", out_pix, 48'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 idle after reset", out_pix, 48'd0);

      last_exp = '0;
      for (int i = 0; i < NV; i++) begin
         {op_sel, bright_up, bright_amt, thr_level, in_pix, last_exp} = VEC[i];
         in_valid = 1'b1;
         @(negedge clk);
         chk($sformatf("R8 vector %0d valid", i), {47'd0, out_valid}, 48'd1);
         chk($sformatf("R1-table vector %0d data", i), out_pix, last_exp);
      end

      // R8: valid drops one cycle after the input strobe; R9: data holds.
      in_valid = 1'b0;
      @(negedge clk);
      chk("R8 valid low after stream", {47'd0, out_valid}, 48'd0);
      chk("R9 data held", out_pix, last_exp);
      op_sel = 2'b01; in_pix = 48'h13579B_2468AC; bright_amt = 8'd1;
      @(negedge clk);
      chk("R9 config change ignored", out_pix, last_exp);
      op_sel = 2'b10; thr_level = 8'd0;
      @(negedge clk);
      chk("R9 data change ignored", out_pix, last_exp);

      // R8: single-beat pulse, result on the next edge only.
      op_sel = 2'b11; in_pix = 48'h010203_040506; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 pulse valid", {47'd0, out_valid}, 48'd1);
      chk("R7 pulse data", out_pix, 48'h010203_040506);
      @(negedge clk);
      chk("R8 pulse valid drop", {47'd0, out_valid}, 48'd0);
      chk("R9 pulse data held", out_pix, 48'h010203_040506);

      // R10: reset in mid operation clears the output.
      rst_n = 1'b0;
      #1;
      chk("R10 async clear", out_pix, 48'd0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule